// File: doc/BRIEF.md
# Seconds Counter With Match Alarm

This block is a real-time clock peripheral that sits on a simple 32-bit register bus. A free-running seconds counter advances once for each pulse on a one-per-second tick enable, which comes from a prescaler outside the block. Software can read the count at any time and can overwrite it by writing a load register. Counting then carries on from the written value.

A match register holds an alarm time. When a tick carries the counter onto that exact value, a raw alarm status bit is set. The counter wraps from all-ones to zero, so an alarm that is set numerically below the current count fires after the wrap. A mask bit gates the raw status onto a single level-sensitive interrupt line. Software clears the alarm by writing any value to a clear register. Eight identification bytes, one per word, occupy the top of the 4 KB register window.

The bus is a plain single-cycle write strobe with a byte address. Read data follows the address combinationally in the default build, or one cycle later when the registered read option is selected.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: A synchronous reset sets the counter, match value, load value, mask and raw status to 0 and drives `irq` low.
- R2: Each cycle with `tick_1hz` high and no load write increments the counter by one. The count is read at offset 0x000.
- R3: A write to offset 0x008 loads the written value into the counter. This load wins over a tick in the same cycle, and counting resumes from the loaded value.
- R4: The counter wraps from 0xFFFFFFFF to 0. A match value below the current count fires once the count wraps round to it.
- R5: The raw status (bit 0 at offset 0x014) is set only when a tick advances the counter onto the match value.
- R6: A write of any data to offset 0x01C clears the raw status.
- R7: Offset 0x00C always reads 0x00000001, and writes to it have no effect.
- R8: `irq` equals the raw status AND the mask bit (bit 0 of offset 0x010). The same value reads back as bit 0 at offset 0x018.
- R9: The match register (0x004) and load register (0x008) read back their last written 32-bit values. The mask register reads back its last written bit 0.
- R10: When a counter hit and a clear write fall in the same cycle, the raw status ends up set.
- R11: Byte offsets 0xFE0 to 0xFFC read one identification byte per word in bits 7:0: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in rising address order.
- R12: Reads of offset 0x01C or of any unmapped offset return 0. Writes to offsets 0x000, 0x014, 0x018 or unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse per second, advances the counter |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte address within the register window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| irq | output | 1 | Level alarm interrupt, raw status AND mask |

## Verification
On every cycle, the embedded properties check the following: the counter's single-step advance, that a load takes precedence, that a raw status bit can only rise after a hit, that a hit beats a clear, that an unopposed clear works, and that the match value holds when it is not written. The bench's scenarios are needed for the rest: the register map decode, the identification bytes, the constant control value, the silence of read-only and unmapped writes, the wrap with a match below the count, and the interrupt as seen through the mask.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   // byte offsets inside the register window
   localparam int OFF_COUNT   = 'h000;
   localparam int OFF_MATCH   = 'h004;
   localparam int OFF_LOAD    = 'h008;
   localparam int OFF_CTRL    = 'h00C;
   localparam int OFF_MASK    = 'h010;
   localparam int OFF_RAW     = 'h014;
   localparam int OFF_MASKED  = 'h018;
   localparam int OFF_CLEAR   = 'h01C;
   localparam int OFF_ID_LO   = 'hFE0;
   localparam int OFF_ID_HI   = 'hFFC;

   // identification bytes, index 0 at the lowest ID address
   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0: b = 8'h31;
         3'd1: b = 8'h10;
         3'd2: b = 8'h14;
         3'd3: b = 8'h00;
         3'd4: b = 8'h0D;
         3'd5: b = 8'hF0;
         3'd6: b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_next,
   output logic             step
);
   assign step     = tick & ~load_en;
   assign cnt_next = cnt + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst)          cnt <= '0;
      else if (load_en) cnt <= load_val;
      else if (tick)    cnt <= cnt_next;
   end

   // a tick without load moves the count forward by exactly one (wraps)
   assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
      (tick && !load_en) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // a load write wins over a simultaneous tick
   assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (cnt == $past(load_val)));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_next,
   input  logic [CNT_W-1:0] match_val,
   input  logic             clr_wr,
   input  logic             mask,
   output logic             raw,
   output logic             irq
);
   logic hit;

   // exact equality on the wrapped value: below-count matches fire after wrap
   assign hit = step && (cnt_next == match_val);

   always_ff @(posedge clk) begin
      if (rst)         raw <= 1'b0;
      else if (hit)    raw <= 1'b1;
      else if (clr_wr) raw <= 1'b0;
   end

   assign irq = raw & mask;

   assert_hit_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
      hit |=> raw);

   assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && !hit) |=> !raw);

   assert_raw_only_on_hit_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(raw) |-> $past(hit));
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cnt,
   input  logic              raw,
   input  logic              irq,
   output logic [DATA_W-1:0] match_q,
   output logic              mask_q,
   output logic              load_en,
   output logic              clr_wr,
   output logic [DATA_W-1:0] rdata
);
   import rtc_pkg::*;

   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] W_COUNT  = WORD_W'(OFF_COUNT  >> 2);
   localparam logic [WORD_W-1:0] W_MATCH  = WORD_W'(OFF_MATCH  >> 2);
   localparam logic [WORD_W-1:0] W_LOAD   = WORD_W'(OFF_LOAD   >> 2);
   localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(OFF_CTRL   >> 2);
   localparam logic [WORD_W-1:0] W_MASK   = WORD_W'(OFF_MASK   >> 2);
   localparam logic [WORD_W-1:0] W_RAW    = WORD_W'(OFF_RAW    >> 2);
   localparam logic [WORD_W-1:0] W_MASKED = WORD_W'(OFF_MASKED >> 2);
   localparam logic [WORD_W-1:0] W_CLEAR  = WORD_W'(OFF_CLEAR  >> 2);
   localparam logic [WORD_W-1:0] W_ID_LO  = WORD_W'(OFF_ID_LO  >> 2);
   localparam logic [WORD_W-1:0] W_ID_HI  = WORD_W'(OFF_ID_HI  >> 2);

   logic [WORD_W-1:0] word;
   logic              unused_lo;
   logic [DATA_W-1:0] load_q;
   logic [DATA_W-1:0] rd_next;
   logic              match_wr, mask_wr;

   assign word      = addr[ADDR_W-1:2];
   assign unused_lo = ^addr[1:0];

   assign match_wr = wr_en && (word == W_MATCH);
   assign mask_wr  = wr_en && (word == W_MASK);
   assign load_en  = wr_en && (word == W_LOAD);
   assign clr_wr   = wr_en && (word == W_CLEAR);

   always_ff @(posedge clk) begin
      if (rst) begin
         match_q <= '0;
         load_q  <= '0;
         mask_q  <= 1'b0;
      end else begin
         if (match_wr) match_q <= wdata;
         if (load_en)  load_q  <= wdata;
         if (mask_wr)  mask_q  <= wdata[0];
      end
   end

   always_comb begin
      rd_next = '0;
      if (word >= W_ID_LO && word <= W_ID_HI) begin
         rd_next = DATA_W'(id_byte(word[2:0]));
      end else begin
         case (word)
            W_COUNT:  rd_next = cnt;
            W_MATCH:  rd_next = match_q;
            W_LOAD:   rd_next = load_q;
            W_CTRL:   rd_next = DATA_W'(1);
            W_MASK:   rd_next = DATA_W'(mask_q);
            W_RAW:    rd_next = DATA_W'(raw);
            W_MASKED: rd_next = DATA_W'(irq);
            default:  rd_next = '0;
         endcase
      end
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk) begin
            if (rst) rdata <= '0;
            else     rdata <= rd_next;
         end
      end else begin : g_rd_comb
         assign rdata = rd_next;
      end
   endgenerate

   // the alarm time only changes through its own offset
   assert_match_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !match_wr |=> $stable(match_q));
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_1hz,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must hold an identification byte");
      end
      if (ADDR_W < 12) begin : g_bad_addr_w
         $error("ADDR_W must span the 4 KB window");
      end
   endgenerate

   logic [DATA_W-1:0] cnt, cnt_next, match_q;
   logic              step, load_en, clr_wr, mask_q, raw;

   rtc_tick_counter #(.CNT_W(DATA_W)) u_cnt (
      .clk(clk), .rst(rst), .tick(tick_1hz), .load_en(load_en),
      .load_val(wdata), .cnt(cnt), .cnt_next(cnt_next), .step(step)
   );

   rtc_alarm_irq #(.CNT_W(DATA_W)) u_alarm (
      .clk(clk), .rst(rst), .step(step), .cnt_next(cnt_next),
      .match_val(match_q), .clr_wr(clr_wr), .mask(mask_q),
      .raw(raw), .irq(irq)
   );

   rtc_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RDATA_REG(RDATA_REG)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cnt(cnt), .raw(raw), .irq(irq), .match_q(match_q), .mask_q(mask_q),
      .load_en(load_en), .clr_wr(clr_wr), .rdata(rdata)
   );
endmodule

// File: tb/tb_rtc_seconds_alarm.sv
`timescale 1ns/1ps
module tb_rtc_seconds_alarm;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_1hz = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rtc_seconds_alarm dut (
      .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // op: 0 write, 1 read-check, 2 ticks (count in data), 3 irq-check
   localparam int NV = 40;
   localparam logic [81:0] VEC [NV] = '{
      {2'd1, 4'd1,  12'h000, 32'h0,        32'h0},        // R1 count after reset
      {2'd1, 4'd7,  12'h00C, 32'h0,        32'h1},        // R7
      {2'd0, 4'd3,  12'h008, 32'h100,      32'h0},        // R3 load
      {2'd1, 4'd3,  12'h000, 32'h0,        32'h100},
      {2'd1, 4'd9,  12'h008, 32'h0,        32'h100},      // R9
      {2'd2, 4'd2,  12'h000, 32'd3,        32'h0},        // R2
      {2'd1, 4'd2,  12'h000, 32'h0,        32'h103},
      {2'd0, 4'd9,  12'h004, 32'h105,      32'h0},
      {2'd1, 4'd9,  12'h004, 32'h0,        32'h105},
      {2'd0, 4'd9,  12'h010, 32'h1,        32'h0},
      {2'd1, 4'd9,  12'h010, 32'h0,        32'h1},
      {2'd2, 4'd5,  12'h000, 32'd1,        32'h0},        // R5 one short
      {2'd1, 4'd5,  12'h014, 32'h0,        32'h0},
      {2'd3, 4'd8,  12'h000, 32'h0,        32'h0},
      {2'd2, 4'd5,  12'h000, 32'd1,        32'h0},        // R5 hit
      {2'd1, 4'd5,  12'h014, 32'h0,        32'h1},
      {2'd1, 4'd8,  12'h018, 32'h0,        32'h1},        // R8
      {2'd3, 4'd8,  12'h000, 32'h0,        32'h1},
      {2'd0, 4'd6,  12'h01C, 32'hDEAD0000, 32'h0},        // R6 bit0 = 0
      {2'd1, 4'd6,  12'h014, 32'h0,        32'h0},
      {2'd3, 4'd6,  12'h000, 32'h0,        32'h0},
      {2'd1, 4'd11, 12'hFE0, 32'h0,        32'h31},       // R11
      {2'd1, 4'd11, 12'hFE4, 32'h0,        32'h10},
      {2'd1, 4'd11, 12'hFE8, 32'h0,        32'h14},
      {2'd1, 4'd11, 12'hFEC, 32'h0,        32'h00},
      {2'd1, 4'd11, 12'hFF0, 32'h0,        32'h0D},
      {2'd1, 4'd11, 12'hFF4, 32'h0,        32'hF0},
      {2'd1, 4'd11, 12'hFF8, 32'h0,        32'h05},
      {2'd1, 4'd11, 12'hFFC, 32'h0,        32'hB1},
      {2'd1, 4'd12, 12'h01C, 32'h0,        32'h0},        // R12
      {2'd1, 4'd12, 12'h020, 32'h0,        32'h0},
      {2'd0, 4'd12, 12'h000, 32'h55,       32'h0},
      {2'd1, 4'd12, 12'h000, 32'h0,        32'h105},
      {2'd0, 4'd12, 12'h014, 32'h1,        32'h0},
      {2'd1, 4'd12, 12'h014, 32'h0,        32'h0},
      {2'd0, 4'd12, 12'h00C, 32'h0,        32'h0},
      {2'd1, 4'd7,  12'h00C, 32'h0,        32'h1},
      {2'd0, 4'd12, 12'h800, 32'hFFFFFFFF, 32'h0},
      {2'd1, 4'd12, 12'h004, 32'h0,        32'h105},
      {2'd1, 4'd12, 12'h7FC, 32'h0,        32'h0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      addr = a;
      #1 chk(req, rdata, exp);
   endtask

   task automatic irq_chk(input logic exp, input string req);
      @(negedge clk);
      #1 chk(req, {31'b0, irq}, {31'b0, exp});
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_1hz = 1'b1;
         @(negedge clk); tick_1hz = 1'b0;
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      irq_chk(1'b0, "R1 irq after reset");

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("R%0d vec %0d", VEC[v][79:76], v);
         case (VEC[v][81:80])
            2'd0: wr(VEC[v][75:64], VEC[v][63:32]);
            2'd1: rd(VEC[v][75:64], VEC[v][31:0], tag);
            2'd2: tk(int'(VEC[v][63:32]));
            default: irq_chk(VEC[v][0], tag);
         endcase
      end

      // R4: wrap with match numerically below the count
      wr(12'h008, 32'hFFFFFFFE);
      wr(12'h004, 32'h0);
      wr(12'h01C, 32'h0);
      wr(12'h010, 32'h1);
      tk(1);
      rd(12'h000, 32'hFFFFFFFF, "R4 top of range");
      rd(12'h014, 32'h0, "R5 not yet matched");
      tk(1);
      rd(12'h000, 32'h0, "R4 wrapped");
      rd(12'h014, 32'h1, "R4 alarm after wrap");
      irq_chk(1'b1, "R8 irq raised");

      // R8: mask off hides the alarm but keeps raw
      wr(12'h010, 32'h0);
      irq_chk(1'b0, "R8 masked irq");
      rd(12'h018, 32'h0, "R8 masked status");
      rd(12'h014, 32'h1, "R8 raw kept");

      // R10: hit and clear in the same cycle
      wr(12'h01C, 32'h0);
      wr(12'h004, 32'h2);
      tk(1);
      @(negedge clk);
      tick_1hz = 1'b1; wr_en = 1'b1; addr = 12'h01C; wdata = 32'h1;
      @(negedge clk);
      tick_1hz = 1'b0; wr_en = 1'b0;
      rd(12'h000, 32'h2, "R10 count");
      rd(12'h014, 32'h1, "R10 set beats clear");

      // R3: load and tick in the same cycle
      @(negedge clk);
      tick_1hz = 1'b1; wr_en = 1'b1; addr = 12'h008; wdata = 32'h500;
      @(negedge clk);
      tick_1hz = 1'b0; wr_en = 1'b0;
      rd(12'h000, 32'h500, "R3 load wins over tick");
      tk(1);
      rd(12'h000, 32'h501, "R3 counting from load");

      // R1: reset from a busy state
      wr(12'h010, 32'h1);
      irq_chk(1'b1, "R8 irq before reset");
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      irq_chk(1'b0, "R1 irq low");
      rd(12'h000, 32'h0, "R1 count");
      rd(12'h004, 32'h0, "R1 match");
      rd(12'h010, 32'h0, "R1 mask");
      rd(12'h014, 32'h0, "R1 raw");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule